// File: doc/BRIEF.md
# GPIO Bank with Both-Edge Change Interrupts

This block is a register-mapped bank of general-purpose I/O lines, with between 1 and 32 lines set by a parameter. Software chooses a direction for each line, writes output values through a single data register, and reads back a mix of synchronised pin levels and driven values. Every input line runs through a multi-flop synchroniser. Any rising or falling transition on a line that is configured as an input is recorded in a sticky change register.

One interrupt output goes high while any line has both a pending change and its enable bit set. Software acknowledges a line by writing a 1 to that line's bit in the change register. A write-mask register selects which output bits a data write may modify. An interrupt-type register exists only as storage for software and does not affect detection.

The bus is a simple single-cycle interface. A write takes effect on the clock edge where the enable and write strobes are both high. Read data is a combinational function of the byte address.

Top module: `pio_bank`

## Requirements
- R1: After reset, the direction, data output, interrupt enable and change registers read zero. The write mask and interrupt type read all ones over the implemented lines. The interrupt output is low.
- R2: The direction register is at byte offset 0x00. A 1 in a bit makes that line an output, and the bit appears on `pinOe` one cycle after the write. A 0 makes the line an input.
- R3: A write to the data register (offset 0x04) changes only those output bits whose write-mask bit (offset 0x10) is 1. `pinOut` holds its value unless a data write occurs.
- R4: A read of offset 0x04 returns the driven value for output lines and the synchronised pin for input lines. A pin change that is applied before clock edge k becomes visible after edge k+1.
- R5: Both rising and falling edges on an input line set its bit in the change register (offset 0x0C), after edge k+2 for a pin change applied before edge k. Transitions on output lines set nothing.
- R6: Change bits stay set until software writes a 1 to them. Writing 0 has no effect.
- R7: When an edge arrives in the same cycle as an acknowledge write to its bit, the bit stays set. Other acknowledged bits clear.
- R8: `irqOut` is high exactly when the bitwise AND of the change register and the enable register (offset 0x08) is nonzero.
- R9: The interrupt-type register (offset 0x14) is plain read/write storage. Writing it to zero does not stop edge detection.
- R10: Bits at or above NUM_LINES read as zero and ignore writes. Offsets 0x18 and 0x1C read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busEn | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 for a write access |
| busAddr | input | ADDR_W | Byte address; word select is bits [ADDR_W-1:2] |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| pinIn | input | NUM_LINES | Asynchronous pin levels |
| pinOut | output | NUM_LINES | Driven output values |
| pinOe | output | NUM_LINES | Output enables (direction register) |
| irqOut | output | 1 | Summary change interrupt |

## Verification
The collision case is a new edge on one line arriving in the same cycle as a software acknowledge of the change register. The bench toggles a pin, counts two clock edges so that the edge reaches the detector, and then issues an all-ones acknowledge in exactly that cycle. The toggled line must remain pending, and a bit that was set earlier must clear. A second overlap is a masked data write while lines change direction; randomized writes to every register are checked against a bench model of mask, direction and pin state.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
  // Register word index = byte offset / 4
  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_DATA = 3'd1,
    SEL_IEN  = 3'd2,
    SEL_CHG  = 3'd3,
    SEL_MASK = 3'd4,
    SEL_TYPE = 3'd5,
    SEL_NONE = 3'd6
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrData;
    logic    wrIen;
    logic    wrChg;
    logic    wrMask;
    logic    wrType;
    regSel_e rdSel;
  } pioStrobe_t;
endpackage

// File: rtl/pio_ctrl.sv
`timescale 1ns/1ps
module pio_ctrl #(
  parameter int ADDR_W = 5
) (
  input  logic                   busEn,
  input  logic                   busWr,
  input  logic [ADDR_W-1:0]      busAddr,
  output pio_pkg::pioStrobe_t    strb
);
  import pio_pkg::*;

  localparam int WORD_W = ADDR_W - 2;
  localparam int NUM_REGS = 6;

  logic [WORD_W-1:0] word;
  logic              unusedAddrBits;
  regSel_e           sel;
  logic              wrAcc;

  assign word           = busAddr[ADDR_W-1:2];
  assign unusedAddrBits = ^busAddr[1:0];
  assign wrAcc          = busEn & busWr;

  always_comb begin
    sel = SEL_NONE;
    if (word < WORD_W'(NUM_REGS)) sel = regSel_e'(word[2:0]);
  end

  always_comb begin
    strb.rdSel  = sel;
    strb.wrDir  = wrAcc && (sel == SEL_DIR);
    strb.wrData = wrAcc && (sel == SEL_DATA);
    strb.wrIen  = wrAcc && (sel == SEL_IEN);
    strb.wrChg  = wrAcc && (sel == SEL_CHG);
    strb.wrMask = wrAcc && (sel == SEL_MASK);
    strb.wrType = wrAcc && (sel == SEL_TYPE);
  end
endmodule

// File: rtl/pio_datapath.sv
`timescale 1ns/1ps
module pio_datapath #(
  parameter int NUM_LINES   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pio_pkg::pioStrobe_t  strb,
  input  logic [31:0]          wdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [31:0]          rdata,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic [NUM_LINES-1:0] chgVec,
  output logic [NUM_LINES-1:0] ienVec,
  output logic                 irq
);
  import pio_pkg::*;

  localparam int NL = NUM_LINES;

  logic [SYNC_STAGES-1:0][NL-1:0] syncPipe;
  logic [NL-1:0] pinSync, prevPin, edgeHit;
  logic [NL-1:0] dirReg, outReg, ienReg, chgReg, maskReg, typeReg;
  logic [NL-1:0] wd, readLines;

  assign wd = wdata[NL-1:0];

  generate
    if (NL < 32) begin : gUnusedHigh
      logic unusedHighBits;
      assign unusedHighBits = ^wdata[31:NL];
    end
  endgenerate

  // Input synchroniser and previous-value register for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPipe <= '0;
      prevPin  <= '0;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], pinIn};
      prevPin  <= pinSync;
    end
  end

  assign pinSync = syncPipe[SYNC_STAGES-1];
  assign edgeHit = (pinSync ^ prevPin) & ~dirReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg  <= '0;
      outReg  <= '0;
      ienReg  <= '0;
      chgReg  <= '0;
      maskReg <= '1;
      typeReg <= '1;
    end else begin
      if (strb.wrDir)  dirReg  <= wd;
      if (strb.wrData) outReg  <= (outReg & ~maskReg) | (wd & maskReg);
      if (strb.wrIen)  ienReg  <= wd;
      if (strb.wrMask) maskReg <= wd;
      if (strb.wrType) typeReg <= wd;
      // a fresh edge wins over an acknowledge in the same cycle
      chgReg <= (chgReg & ~(strb.wrChg ? wd : '0)) | edgeHit;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_DIR:  readLines = dirReg;
      SEL_DATA: readLines = (dirReg & outReg) | (~dirReg & pinSync);
      SEL_IEN:  readLines = ienReg;
      SEL_CHG:  readLines = chgReg;
      SEL_MASK: readLines = maskReg;
      SEL_TYPE: readLines = typeReg;
      default:  readLines = '0;
    endcase
  end

  assign rdata  = 32'(readLines);
  assign pinOut = outReg;
  assign pinOe  = dirReg;
  assign chgVec = chgReg;
  assign ienVec = ienReg;
  assign irq    = |(chgReg & ienReg);
endmodule

// File: rtl/pio_bank.sv
`timescale 1ns/1ps
module pio_bank #(
  parameter int NUM_LINES   = 12,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busEn,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic                 irqOut
);
  import pio_pkg::*;

  pioStrobe_t           strb;
  logic [NUM_LINES-1:0] chgVec, ienVec;

  pio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busEn(busEn), .busWr(busWr), .busAddr(busAddr), .strb(strb)
  );

  pio_datapath #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .pinIn(pinIn),
    .rdata(busRdata), .pinOut(pinOut), .pinOe(pinOe),
    .chgVec(chgVec), .ienVec(ienVec), .irq(irqOut)
  );
endmodule

// File: rtl/pio_bank_chk.sv
`timescale 1ns/1ps
module pio_bank_chk #(
  parameter int NUM_LINES = 12,
  parameter int ADDR_W    = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-3:0]    busWord,
  input logic [NUM_LINES-1:0] busWdata,
  input logic [NUM_LINES-1:0] pinOut,
  input logic [NUM_LINES-1:0] pinOe,
  input logic                 irqOut,
  input logic [NUM_LINES-1:0] chgVec,
  input logic [NUM_LINES-1:0] ienVec
);
  logic wrDir, wrData, wrIen, wrChg;
  assign wrDir  = wrEn && (busWord == (ADDR_W-2)'(0));
  assign wrData = wrEn && (busWord == (ADDR_W-2)'(1));
  assign wrIen  = wrEn && (busWord == (ADDR_W-2)'(2));
  assign wrChg  = wrEn && (busWord == (ADDR_W-2)'(3));

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rstN)
    wrDir |=> pinOe == $past(busWdata)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrData |=> $stable(pinOut)); // R3
  AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !wrChg |=> (chgVec & $past(chgVec)) == $past(chgVec)); // R6
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (chgVec != '0)); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (ienVec == '0) |-> !irqOut); // R8
  AST_IEN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrIen |=> ienVec == $past(busWdata)); // R8
endmodule

bind pio_bank pio_bank_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(busEn & busWr),
  .busWord(busAddr[ADDR_W-1:2]), .busWdata(busWdata[NUM_LINES-1:0]),
  .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut),
  .chgVec(chgVec), .ienVec(ienVec)
);

// File: tb/pio_bank_test.sv
`timescale 1ns/1ps
module pio_bank_test;
  localparam int NL = 12;
  localparam int AW = 5;
  localparam logic [31:0] LM = (32'h1 << NL) - 32'h1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          busEn = 1'b0, busWr = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0;
  wire  [31:0]   busRdata;
  logic [NL-1:0] pinIn = '0;
  wire  [NL-1:0] pinOut, pinOe;
  wire           irqOut;

  pio_bank #(.NUM_LINES(NL), .SYNC_STAGES(2), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  int nChk = 0, nFail = 0;
  logic [31:0] mDir, mOut, mIen, mChg, mMask, mTyp, mPin;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [31:0] addr);
    case (addr)
      32'h00: return mDir;
      32'h04: return ((mDir & mOut) | (~mDir & mPin)) & LM;
      32'h08: return mIen;
      32'h0C: return mChg;
      32'h10: return mMask;
      32'h14: return mTyp;
      default: return 32'h0;
    endcase
  endfunction

  task automatic busRead(input logic [31:0] addr, output logic [31:0] data);
    busAddr = addr[AW-1:0];
    #0.5;
    data = busRdata;
  endtask

  task automatic busWrite(input logic [31:0] addr, input logic [31:0] d);
    @(negedge clk);
    busEn = 1'b1; busWr = 1'b1; busAddr = addr[AW-1:0]; busWdata = d;
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
    case (addr)
      32'h00: mDir = d & LM;
      32'h04: mOut = (mOut & ~mMask) | (d & mMask);
      32'h08: mIen = d & LM;
      32'h0C: mChg = mChg & ~d;
      32'h10: mMask = d & LM;
      32'h14: mTyp = d & LM;
      default: ;
    endcase
  endtask

  task automatic checkAll(input string req);
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin
      busRead(32'(a * 4), v);
      chk(req, v, expRead(32'(a * 4)));
    end
    chk(req, 32'(pinOut), mOut & LM);
    chk(req, 32'(pinOe), mDir);
    chk(req, 32'(irqOut), 32'(|(mChg & mIen)));
  endtask

  task automatic setPins(input logic [31:0] v);
    @(negedge clk);
    mChg = mChg | ((mPin ^ v) & ~mDir & LM);
    pinIn = v[NL-1:0];
    mPin = v & LM;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v, old;
    void'($urandom(32'd4242));
    mDir = 0; mOut = 0; mIen = 0; mChg = 0; mMask = LM; mTyp = LM; mPin = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 reset values");

    // R10: upper bits and unmapped offsets
    busWrite(32'h00, 32'hFFFF_FFFF);
    busWrite(32'h18, 32'hFFFF_FFFF);
    busWrite(32'h1C, 32'h1234_5678);
    checkAll("R10 upper bits/unmapped");
    busWrite(32'h00, 32'h0);

    // R2/R3: direction and masked data write
    busWrite(32'h00, 32'h0F0);
    busWrite(32'h04, 32'hFFF);
    busWrite(32'h10, 32'h0A5);
    busWrite(32'h04, 32'h000);
    checkAll("R3 masked data write");
    busWrite(32'h10, 32'hFFF);

    // R4/R5 timing: toggle inputs 0,2 and output line 4
    @(negedge clk);
    old = mPin;
    pinIn = 12'h015;
    @(posedge clk); @(negedge clk);
    busRead(32'h04, v);
    chk("R4 data before sync", v, ((mDir & mOut) | (~mDir & old)) & LM);
    @(posedge clk); @(negedge clk);
    busRead(32'h04, v);
    chk("R4 data after sync", v, ((mDir & mOut) | (~mDir & 32'h015)) & LM);
    busRead(32'h0C, v);
    chk("R5 change not yet set", v, 32'h0);
    @(posedge clk); @(negedge clk);
    busRead(32'h0C, v);
    chk("R5 both-edge input only", v, 32'h005);
    mChg = 32'h005; mPin = 32'h015;
    setPins(32'h010);
    checkAll("R5 falling edge");

    // R6: write 0 ignored, write 1 clears
    busWrite(32'h0C, 32'h000);
    checkAll("R6 write zero no effect");
    busWrite(32'h08, 32'h004);
    checkAll("R8 irq with enable");
    busWrite(32'h0C, 32'h004);
    checkAll("R6 write one clears");

    // R7: ack collides with new edge
    busWrite(32'h00, 32'h0);
    busWrite(32'h0C, 32'hFFF);
    setPins(mPin ^ 32'h1);
    @(negedge clk);
    pinIn = NL'(mPin ^ 32'h2);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    busEn = 1'b1; busWr = 1'b1; busAddr = 5'h0C; busWdata = 32'hFFF;
    @(negedge clk);
    busEn = 1'b0; busWr = 1'b0;
    mPin = mPin ^ 32'h2; mChg = 32'h2;
    checkAll("R7 edge beats ack");

    // R9: type register has no effect on detection
    busWrite(32'h14, 32'h0);
    setPins(mPin ^ 32'h800);
    checkAll("R9 type storage only");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 7);
      if (op == 7) setPins($urandom() & LM);
      else busWrite(32'(op * 4), $urandom());
      checkAll("R3/R4/R8 random");
    end
    finishRun();
  end
endmodule